// File: doc/BRIEF.md
# Multi-Function Timer with Capture and PWM

This block is a 16-bit timer channel for a peripheral subsystem. A single free-running up-counter is the time base for every function. In the normal timing modes it advances on ticks from a programmable divider that can slow the system clock by any ratio from 1 to 128. In pulse-count mode it advances on edges of an external pin instead. Two channels share the counter. Each channel either snapshots the count when an edge arrives on its input pin, or watches for the count to reach a programmed value and then drives its output pin.

In PWM mode the counter becomes a modulo counter: channel 0 holds the top of the count and channel 1 holds the duty threshold, so software selects both the output frequency and the duty. Software reaches the block through a simple word-wide register port. It controls the block with a control word, two channel value registers, a write-one-to-clear event register, an interrupt mask and a loadable count register.

Top module: `mft_timer`

## Requirements
- R1: After reset the count, the event register, the interrupt mask, both channel registers, both channel pins, `pwm_out` and `irq` are all 0.
- R2: In free-run mode, with the enable bit (control bit 2) set and divider field (control bits 9:3) equal to N, the count advances by exactly one every N+1 clocks, for N from 0 to 127.
- R3: In free-run mode the count wraps from 0xFFFF to 0, and this sets event bit 0 (overflow).
- R4: In pulse-count mode (control bits 1:0 = 1) the count advances once per rising edge of `pulse_in`, and the divider setting has no effect. Falling edges and a steady level leave the count unchanged.
- R5: A channel configured for capture (its function bit = 0) copies the count into its channel register on the edge picked by its edge bit (0 rising, 1 falling) of its synchronized `cap_in` pin. The capture sets its event bit (bit 1 for channel 0, bit 2 for channel 1). An edge of the other polarity has no effect.
- R6: A channel configured for compare (function bit = 1) acts when the count steps onto its register value. With its action bit = 0 it toggles its `cmp_out` pin; with action bit = 1 it drives the pin to 1. Either way it sets its event bit. The per-channel field is 3 bits at control bit 10 + 3·i, ordered function, edge, action from its low bit.
- R7: In PWM mode (control bits 1:0 = 2) the count runs from 0 to the channel 0 value and then restarts at 0, giving a period of value+1 ticks. `pwm_out` is high for as many clocks per period as the channel 1 value. It is always low when that value is 0, and always high when that value exceeds the period value.
- R8: Writing the event register clears each bit written as 1; bits written as 0 keep their value.
- R9: `irq` is a registered OR of the event bits ANDed with the interrupt mask (mask bit k enables event bit k).
- R10: With the enable bit clear, the count holds its value.
- R11: Register map (word addresses): 0 control, 1 channel 0, 2 channel 1, 3 events, 4 interrupt mask, 5 count. A write to address 5 loads the count. A read returns data with `bus_rvalid` one clock after `bus_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one clock after `bus_re` |
| pulse_in | input | 1 | External count input for pulse-count mode |
| cap_in | input | 2 | Capture inputs, one per channel |
| cmp_out | output | 2 | Compare output pins, one per channel |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is tried with three different tick sources: divider ratios of 5 and 128, which show whether the divide is N+1 rather than N; a hand-toggled `pulse_in`, where a count of seven edges against a held level shows edge detection rather than level sampling; and a stopped timer, which must hold its count. The capture channels are stimulated with both polarities on a frozen count, so a capture on the wrong edge shows up as a changed register. The compare pins are run through the match twice, which tells toggle apart from set. PWM is measured with duty below, at 0 and above the period, and the number of high clocks per window is compared with the duty.

// File: rtl/mft_pkg.sv
package mft_pkg;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_PWM   = 2'd2,
    MODE_SPARE = 2'd3
  } mft_mode_e;

  // per-channel control field, low bit first: function, edge, action
  typedef struct packed {
    logic act_set;    // compare: 1 = drive high, 0 = toggle
    logic edge_fall;  // capture: 1 = falling edge, 0 = rising edge
    logic is_cmp;     // 1 = compare, 0 = capture
  } ch_cfg_t;

  localparam int NUM_CH = 2;
  localparam int CFG_W  = 3;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_CH0   = 3'd1;
  localparam logic [2:0] A_FLAGS = 3'd3;
  localparam logic [2:0] A_IEN   = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;

endpackage

// File: rtl/mft_edge_sync.sv
module mft_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic sel_fall,
  output logic hit
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign hit = sel_fall ? (last_q & ~sync_q[STAGES-1])
                        : (~last_q & sync_q[STAGES-1]);
endmodule

// File: rtl/mft_prescaler.sv
module mft_prescaler #(
  parameter int PSC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] pc_q;

  assign tick = run && (pc_q >= div);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) pc_q <= '0;
    else if (tick)          pc_q <= '0;
    else                    pc_q <= pc_q + 1'b1;
  end

  // R2
  tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pc_q == '0));

  // R2
  psc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && !tick) |=> (pc_q == $past(pc_q) + 1'b1));
endmodule

// File: rtl/mft_counter.sv
module mft_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             wrap_en,
  input  logic [CNT_W-1:0] wrap_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             stepped,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      stepped <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      stepped <= 1'b0;
      ovf     <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (step) begin
        stepped <= 1'b1;
        if (wrap_en && (cnt >= wrap_val)) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
          ovf <= &cnt;
        end
      end
    end
  end

  // R3
  ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (cnt == '0));

  // R10
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(cnt));

  // R2
  step_incr_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !wrap_en && !(&cnt)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/mft_channel.sv
module mft_channel
  import mft_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ch_cfg_t          cfg,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic             stepped,
  input  logic             edge_hit,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cap_val,
  output logic             pin,
  output logic             evt
);
  logic capture_hit;
  logic match_hit;

  assign capture_hit = active && !cfg.is_cmp && edge_hit;
  assign match_hit   = active && cfg.is_cmp && stepped && (cnt == cap_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val <= '0;
      pin     <= 1'b0;
      evt     <= 1'b0;
    end else begin
      evt <= capture_hit || match_hit;
      if (capture_hit)  cap_val <= cnt;
      else if (wr_en)   cap_val <= wr_data;
      if (match_hit)    pin <= cfg.act_set ? 1'b1 : ~pin;
    end
  end

  // R5
  capture_latch_chk: assert property (@(posedge clk) disable iff (rst)
    capture_hit |=> (cap_val == $past(cnt)));

  // R6
  pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !stepped |=> $stable(pin));
endmodule

// File: rtl/mft_timer.sv
module mft_timer
  import mft_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 7,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              pulse_in,
  input  logic [NUM_CH-1:0] cap_in,
  output logic [NUM_CH-1:0] cmp_out,
  output logic              pwm_out,
  output logic              irq
);
  localparam int FLG_W  = NUM_CH + 1;
  localparam int CH_LSB = 3 + PSC_W;

  logic [CNT_W-1:0] ctrl_q;
  logic [FLG_W-1:0] flags_q, ien_q, set_vec, clr_vec;
  logic             pwm_q, irq_q;
  mft_mode_e        mode;
  logic             en, load, tick_psc, pulse_hit, step;
  logic [CNT_W-1:0] cnt;
  logic             stepped, ovf_evt;
  logic [CNT_W-1:0] ch_val [NUM_CH];
  logic [NUM_CH-1:0] ch_evt, ch_pin;
  logic [CNT_W-1:0] rd_mux;

  assign mode = mft_mode_e'(ctrl_q[1:0]);
  assign en   = ctrl_q[2];
  assign load = bus_we && (bus_addr == A_COUNT);

  mft_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk (clk), .rst (rst),
    .run (en && (mode != MODE_PULSE)),
    .clr (load),
    .div (ctrl_q[3 +: PSC_W]),
    .tick(tick_psc)
  );

  mft_edge_sync #(.STAGES(SYNC_N)) u_pulse_sync (
    .clk(clk), .rst(rst), .din(pulse_in), .sel_fall(1'b0), .hit(pulse_hit)
  );

  assign step = (mode == MODE_PULSE) ? (en && pulse_hit) : tick_psc;

  mft_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk), .rst(rst),
    .step    (step),
    .wrap_en (mode == MODE_PWM),
    .wrap_val(ch_val[0]),
    .load    (load),
    .load_val(bus_wdata),
    .cnt     (cnt),
    .stepped (stepped),
    .ovf     (ovf_evt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ch_cfg_t cfg_i;
    logic    hit_i;
    assign cfg_i = ch_cfg_t'(ctrl_q[CH_LSB + CFG_W*i +: CFG_W]);

    mft_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst(rst), .din(cap_in[i]), .sel_fall(cfg_i.edge_fall), .hit(hit_i)
    );

    mft_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk), .rst(rst),
      .cfg     (cfg_i),
      .active  (mode != MODE_PWM),
      .cnt     (cnt),
      .stepped (stepped),
      .edge_hit(hit_i),
      .wr_en   (bus_we && (bus_addr == A_CH0 + 3'(i))),
      .wr_data (bus_wdata),
      .cap_val (ch_val[i]),
      .pin     (ch_pin[i]),
      .evt     (ch_evt[i])
    );
  end

  assign set_vec = {ch_evt, ovf_evt};
  assign clr_vec = (bus_we && (bus_addr == A_FLAGS)) ? bus_wdata[FLG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      flags_q <= '0;
      pwm_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_we && (bus_addr == A_CTRL)) ctrl_q <= bus_wdata;
      if (bus_we && (bus_addr == A_IEN))  ien_q  <= bus_wdata[FLG_W-1:0];
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      pwm_q   <= en && (mode == MODE_PWM) && (cnt < ch_val[1]);
      irq_q   <= |(flags_q & ien_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:  rd_mux = ctrl_q;
      A_FLAGS: rd_mux = CNT_W'(flags_q);
      A_IEN:   rd_mux = CNT_W'(ien_q);
      A_COUNT: rd_mux = cnt;
      default: rd_mux = '0;
    endcase
    for (int k = 0; k < NUM_CH; k++)
      if (bus_addr == A_CH0 + 3'(k)) rd_mux = ch_val[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  assign cmp_out = ch_pin;
  assign pwm_out = pwm_q;
  assign irq     = irq_q;

  // R8
  flag_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == A_FLAGS) && bus_wdata[0] && !ovf_evt) |=> !flags_q[0]);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ((ien_q == '0) && $past(ien_q == '0)) |-> !irq);
endmodule

// File: tb/test_mft_timer.sv
module test_mft_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        pulse_in = 1'b0;
  logic [1:0]  cap_in = '0;
  logic [1:0]  cmp_out;
  logic        pwm_out, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] last_rd;

  typedef struct {
    bit          chk;
    logic [15:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #5 clk = ~clk;

  mft_timer i_mft_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pulse_in(pulse_in), .cap_in(cap_in), .cmp_out(cmp_out), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (bus_rvalid) begin
      sb_item_t it;
      last_rd = bus_rdata;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected read data actual=%0h expected=none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (it.chk) check(it.tag, int'(bus_rdata), int'(it.exp));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; #1;
  endtask

  task automatic rd(input logic [2:0] a, input bit chk, input logic [15:0] exp, input string tag);
    sb_q.push_back('{chk, exp, tag});
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; #1;
  endtask

  function automatic logic [15:0] cw(input logic [1:0] mode, input logic en,
                                      input logic [6:0] psc, input logic [2:0] c0,
                                      input logic [2:0] c1);
    return {c1, c0, psc, en, mode};
  endfunction

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a0, a1;
    int hi;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;

    // R1 reset state
    rd(3'd5, 1, 16'h0, "R1 count");
    rd(3'd3, 1, 16'h0, "R1 events");
    rd(3'd1, 1, 16'h0, "R1 ch0 reg");
    check("R1 pins", int'({cmp_out, pwm_out, irq}), 0);

    // R2 divide by 5
    wr(3'd0, cw(2'd0, 1'b1, 7'd4, 3'b000, 3'b000));
    repeat (3) @(negedge clk);
    rd(3'd5, 0, 0, ""); a0 = last_rd;
    repeat (49) @(negedge clk);
    rd(3'd5, 0, 0, ""); a1 = last_rd;
    check("R2 divide 5 delta", int'(a1 - a0), 10);

    // R2 divide by 128
    wr(3'd0, cw(2'd0, 1'b1, 7'd127, 3'b000, 3'b000));
    repeat (3) @(negedge clk);
    rd(3'd5, 0, 0, ""); a0 = last_rd;
    repeat (255) @(negedge clk);
    rd(3'd5, 0, 0, ""); a1 = last_rd;
    check("R2 divide 128 delta", int'(a1 - a0), 2);

    // R10 disabled holds
    wr(3'd0, cw(2'd0, 1'b0, 7'd0, 3'b000, 3'b000));
    rd(3'd5, 0, 0, ""); a0 = last_rd;
    repeat (20) @(negedge clk);
    rd(3'd5, 1, a0, "R10 held count");

    // R3 overflow, R9 irq, R8 W1C
    wr(3'd3, 16'h7);
    wr(3'd4, 16'h1);
    wr(3'd5, 16'hFFFD);
    wr(3'd0, cw(2'd0, 1'b1, 7'd0, 3'b000, 3'b000));
    repeat (10) @(negedge clk);
    wr(3'd0, cw(2'd0, 1'b0, 7'd0, 3'b000, 3'b000));
    rd(3'd3, 1, 16'h1, "R3 overflow event");
    rd(3'd5, 0, 0, "");
    check("R3 wrapped low", int'(last_rd < 16'd20), 1);
    check("R9 irq set", int'(irq), 1);
    wr(3'd3, 16'h0);
    rd(3'd3, 1, 16'h1, "R8 write zero keeps");
    wr(3'd3, 16'h1);
    rd(3'd3, 1, 16'h0, "R8 write one clears");
    @(negedge clk);
    check("R9 irq cleared", int'(irq), 0);

    // R4 pulse count, divider ignored
    wr(3'd5, 16'h0);
    wr(3'd0, cw(2'd1, 1'b1, 7'd127, 3'b000, 3'b000));
    for (int p = 0; p < 7; p++) begin
      pulse_in = 1'b1; repeat (4) @(negedge clk);
      pulse_in = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(3'd5, 1, 16'd7, "R4 seven rising edges");
    pulse_in = 1'b1; repeat (6) @(negedge clk);
    rd(3'd5, 1, 16'd8, "R4 one more rise");
    repeat (20) @(negedge clk);
    pulse_in = 1'b0; repeat (6) @(negedge clk);
    rd(3'd5, 1, 16'd8, "R4 level and fall ignored");

    // R5 capture: ch0 rising, ch1 falling, counter frozen
    wr(3'd0, cw(2'd0, 1'b0, 7'd0, 3'b000, 3'b010));
    wr(3'd3, 16'h7);
    wr(3'd2, 16'hAAAA);
    wr(3'd5, 16'h1234);
    cap_in = 2'b11; repeat (6) @(negedge clk);
    rd(3'd1, 1, 16'h1234, "R5 ch0 rising capture");
    rd(3'd2, 1, 16'hAAAA, "R5 ch1 ignores rising");
    rd(3'd3, 1, 16'h2, "R5 ch0 event only");
    wr(3'd5, 16'h5678);
    cap_in = 2'b00; repeat (6) @(negedge clk);
    rd(3'd2, 1, 16'h5678, "R5 ch1 falling capture");
    rd(3'd1, 1, 16'h1234, "R5 ch0 ignores falling");
    rd(3'd3, 1, 16'h6, "R5 both events");

    // R6 compare: ch0 toggle, ch1 set
    wr(3'd3, 16'h7);
    wr(3'd1, 16'd20);
    wr(3'd2, 16'd30);
    wr(3'd5, 16'h0);
    wr(3'd0, cw(2'd0, 1'b1, 7'd0, 3'b001, 3'b101));
    repeat (5) @(negedge clk);
    check("R6 pins before match", int'(cmp_out), 0);
    repeat (45) @(negedge clk);
    wr(3'd0, cw(2'd0, 1'b0, 7'd0, 3'b001, 3'b101));
    check("R6 both pins after first match", int'(cmp_out), 3);
    rd(3'd3, 1, 16'h6, "R6 compare events");
    wr(3'd5, 16'd15);
    wr(3'd0, cw(2'd0, 1'b1, 7'd0, 3'b001, 3'b101));
    repeat (20) @(negedge clk);
    wr(3'd0, cw(2'd0, 1'b0, 7'd0, 3'b001, 3'b101));
    check("R6 toggle vs set", int'(cmp_out), 2);

    // R7 PWM period 10, duty 3
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd3);
    wr(3'd0, cw(2'd2, 1'b1, 7'd0, 3'b000, 3'b000));
    repeat (25) @(negedge clk);
    count_high(10, hi);
    check("R7 duty 3 of 10", hi, 3);
    count_high(20, hi);
    check("R7 duty 6 of 20", hi, 6);
    rd(3'd5, 0, 0, "");
    check("R7 count within period", int'(last_rd <= 16'd9), 1);
    wr(3'd2, 16'd0);
    repeat (12) @(negedge clk);
    count_high(20, hi);
    check("R7 duty zero", hi, 0);
    wr(3'd2, 16'd12);
    repeat (12) @(negedge clk);
    count_high(20, hi);
    check("R7 duty above period", hi, 20);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule